// File: doc/BRIEF.md
# Manchester Frame Receiver

This block takes a Manchester-coded serial line and recovers framed byte data from it. A local clock runs at a fixed multiple of the bit rate, 16 by default. The line passes through a two-flop synchroniser. Every edge after that is classified in one of two ways. An edge that comes at least three quarters of a cell after the previous mid-cell edge is taken as the next mid-cell edge. An edge that comes sooner is a cell-boundary edge and is ignored. The edge direction gives the bit value. Each accepted mid-cell edge restarts the cell timer, so timing is re-aligned once per bit.

While hunting, the receiver counts a run of alternating bits, which is the preamble. Once the run is long enough, two consecutive 1 bits mark the delimiter. The bit after the second 1 is the first data bit. Data bits are packed least significant bit first into bytes, and each finished byte is announced with a one-clock strobe. If the line stays quiet for more than one and a half cells during data, the receiver pulses an end-of-frame flag, drops any unfinished byte and goes back to hunting.

Top module: `mrx_receiver`

## Requirements
- R1: While reset is high and in the first cycle after it, `byte_valid` and `frame_end` are 0 and `rx_byte` is 0.
- R2: A rising mid-cell edge (line low in the first half of the cell, high in the second) decodes as bit 1. A falling mid-cell edge decodes as bit 0.
- R3: An edge arriving fewer than 3·OSR/4 clocks after the last accepted mid-cell edge produces no bit. Runs of equal bits, which have boundary edges, therefore decode correctly.
- R4: Data output is enabled only after a run of at least PRE_MIN alternating bits, counted up to and including the first 1 of the delimiter. With a shorter run, no byte and no end-of-frame is produced for that frame.
- R5: The delimiter is two consecutive 1 bits. The bit that follows them is bit 0 of the first data byte.
- R6: Bytes are assembled least significant bit first. `byte_valid` is high for exactly one clock per byte, and `rx_byte` changes only in a cycle where `byte_valid` is high.
- R7: When no mid-cell edge arrives for 3·OSR/2 clocks during the data phase, `frame_end` pulses for one clock and the receiver returns to hunting. `frame_end` never coincides with `byte_valid`.
- R8: A byte left unfinished at end of frame is never delivered, and the next frame's bytes line up from its own first data bit.
- R9: A frame can carry any number of bytes, delivered back to back without gaps in bit timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OSR times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous Manchester-coded serial input |
| rx_byte | output | DATA_W | Last completed data byte |
| byte_valid | output | 1 | One-clock strobe for a new `rx_byte` |
| frame_end | output | 1 | One-clock pulse when the line goes idle during data |

## Verification
The bench sends whole frames with payloads made of runs of equal bits (0x00, 0xFF) and of dense alternation (0xA5, 0x5A). A receiver that counted boundary edges as bits would add extra bits to the first kind, and one with swapped polarity would invert every byte. A preamble one bit too short must give no output at all, which catches a lock threshold that is off by one. A frame that ends partway through a byte must deliver only its whole bytes and then one end-of-frame pulse. The frame after it must be byte-aligned again, which exposes a bit counter that is not cleared.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    typedef enum logic [0:0] {
        PH_HUNT = 1'b0,
        PH_DATA = 1'b1
    } phase_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic stb;
        logic val;
    } bit_evt_t;

    function automatic int mid_min(input int osr);
        return (osr * 3) / 4;
    endfunction

    function automatic int idle_lim(input int osr);
        return (osr * 3) / 2;
    endfunction

endpackage

// File: rtl/mrx_sync.sv
module mrx_sync
    import mrx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output edge_t edge_o
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], din};
    end

    always_comb begin
        edge_o.rise = pipe[STAGES-1] & ~pipe[STAGES];
        edge_o.fall = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/mrx_timing.sv
module mrx_timing
    import mrx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  edge_t    edge_i,
    output bit_evt_t bit_o,
    output logic     idle_o
);
    localparam int MID_MIN = mid_min(OSR);
    localparam int IDLE_LIM = idle_lim(OSR);
    localparam int CNT_W = $clog2(IDLE_LIM + 1);
    localparam logic [CNT_W-1:0] MID_C = CNT_W'(MID_MIN);
    localparam logic [CNT_W-1:0] SAT_C = CNT_W'(IDLE_LIM);

    logic [CNT_W-1:0] cnt;
    logic             any_edge;

    assign any_edge = edge_i.rise | edge_i.fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= SAT_C;
            bit_o  <= '0;
            idle_o <= 1'b0;
        end else begin
            bit_o.stb <= 1'b0;
            idle_o    <= 1'b0;
            if (any_edge && cnt >= MID_C) begin
                cnt   <= '0;
                bit_o <= '{stb: 1'b1, val: edge_i.rise};
            end else if (cnt != SAT_C) begin
                cnt <= cnt + 1'b1;
                if (cnt == SAT_C - 1'b1) idle_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mrx_framer.sv
module mrx_framer
    import mrx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PRE_MIN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bit_evt_t          bit_i,
    input  logic              idle_i,
    output logic [DATA_W-1:0] rx_byte,
    output logic              byte_valid,
    output logic              frame_end
);
    localparam int ALT_W = $clog2(PRE_MIN + 1);
    localparam int BC_W  = $clog2(DATA_W);
    localparam logic [ALT_W-1:0] ALT_MAX = ALT_W'(PRE_MIN);
    localparam logic [BC_W-1:0]  BC_LAST = BC_W'(DATA_W - 1);

    phase_t            phase;
    logic              last_bit;
    logic [ALT_W-1:0]  alt_cnt;
    logic [DATA_W-1:0] shreg;
    logic [BC_W-1:0]   bcnt;
    logic [DATA_W-1:0] next_sh;

    assign next_sh = {bit_i.val, shreg[DATA_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_HUNT;
            last_bit   <= 1'b0;
            alt_cnt    <= '0;
            shreg      <= '0;
            bcnt       <= '0;
            rx_byte    <= '0;
            byte_valid <= 1'b0;
            frame_end  <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            frame_end  <= 1'b0;
            if (idle_i) begin
                if (phase == PH_DATA) frame_end <= 1'b1;
                phase   <= PH_HUNT;
                alt_cnt <= '0;
                bcnt    <= '0;
            end else if (bit_i.stb) begin
                if (phase == PH_HUNT) begin
                    last_bit <= bit_i.val;
                    if (alt_cnt == '0 || bit_i.val != last_bit) begin
                        if (alt_cnt != ALT_MAX) alt_cnt <= alt_cnt + 1'b1;
                    end else if (bit_i.val && alt_cnt == ALT_MAX) begin
                        phase <= PH_DATA;
                        bcnt  <= '0;
                    end else begin
                        alt_cnt <= ALT_W'(1);
                    end
                end else begin
                    shreg <= next_sh;
                    if (bcnt == BC_LAST) begin
                        rx_byte    <= next_sh;
                        byte_valid <= 1'b1;
                        bcnt       <= '0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mrx_receiver.sv
module mrx_receiver
    import mrx_pkg::*;
#(
    parameter int OSR     = 16,
    parameter int DATA_W  = 8,
    parameter int PRE_MIN = 8,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    output logic [DATA_W-1:0] rx_byte,
    output logic              byte_valid,
    output logic              frame_end
);
    edge_t    line_edge;
    bit_evt_t bit_evt;
    logic     idle_evt;

    mrx_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .din(rx_line), .edge_o(line_edge)
    );

    mrx_timing #(.OSR(OSR)) u_timing (
        .clk(clk), .rst(rst), .edge_i(line_edge),
        .bit_o(bit_evt), .idle_o(idle_evt)
    );

    mrx_framer #(.DATA_W(DATA_W), .PRE_MIN(PRE_MIN)) u_framer (
        .clk(clk), .rst(rst), .bit_i(bit_evt), .idle_i(idle_evt),
        .rx_byte(rx_byte), .byte_valid(byte_valid), .frame_end(frame_end)
    );
endmodule

// File: rtl/mrx_receiver_chk.sv
module mrx_receiver_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] rx_byte,
    input logic              byte_valid,
    input logic              frame_end
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!byte_valid && !frame_end && rx_byte == '0));

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    p_byte_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |-> $stable(rx_byte));

    p_eof_single_r7: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);

    p_eof_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(frame_end && byte_valid));
endmodule

bind mrx_receiver mrx_receiver_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .rx_byte(rx_byte),
    .byte_valid(byte_valid), .frame_end(frame_end)
);

// File: tb/mrx_receiver_test.sv
module mrx_receiver_test;
    localparam int CLK_PERIOD = 10;
    localparam int OSR = 16;
    localparam int PRE_MIN = 8;

    // {preamble bits, byte count, byte0, byte1}
    localparam logic [31:0] VEC [6] = '{
        {8'd8,  8'd2, 8'hA5, 8'h3C},
        {8'd12, 8'd2, 8'h00, 8'hFF},
        {8'd8,  8'd1, 8'h81, 8'h00},
        {8'd20, 8'd2, 8'h5A, 8'h01},
        {8'd6,  8'd2, 8'hFF, 8'hFF},
        {8'd10, 8'd2, 8'hC3, 8'h7E}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b0;
    logic [7:0] rx_byte;
    logic       byte_valid;
    logic       frame_end;

    int checks = 0;
    int fails = 0;
    int rx_n = 0;
    int eof_n = 0;
    int wide = 0;
    logic       prev_bv = 1'b0;
    logic [7:0] rx_buf [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    mrx_receiver #(.OSR(OSR), .DATA_W(8), .PRE_MIN(PRE_MIN), .SYNC_N(2)) uut (
        .clk(clk), .rst(rst), .rx_line(rx_line),
        .rx_byte(rx_byte), .byte_valid(byte_valid), .frame_end(frame_end)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                if (rx_n < 16) rx_buf[rx_n] = rx_byte;
                rx_n++;
            end
            if (frame_end) eof_n++;
            if (byte_valid && prev_bv) wide++;
        end
        prev_bv = byte_valid;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx_line = ~b;
        repeat (OSR/2) @(negedge clk);
        rx_line = b;
        repeat (OSR/2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic go_idle();
        rx_line = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic start_frame(input int pre);
        rx_n = 0;
        eof_n = 0;
        for (int i = 0; i < pre; i++) send_bit(i % 2 == 0);
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=0", wd);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 byte_valid in reset", int'(byte_valid), 0);
        chk("R1 frame_end in reset", int'(frame_end), 0);
        chk("R1 rx_byte in reset", int'(rx_byte), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 byte_valid after reset", int'(byte_valid), 0);
        go_idle();

        for (int v = 0; v < 6; v++) begin
            int pre = int'(VEC[v][31:24]);
            int nb  = int'(VEC[v][23:16]);
            int ok  = (pre + 1 >= PRE_MIN) ? 1 : 0;
            start_frame(pre);
            send_byte(VEC[v][15:8]);
            if (nb > 1) send_byte(VEC[v][7:0]);
            go_idle();
            // R4 lock threshold, R9 byte count per frame
            chk($sformatf("R4 R9 byte count frame %0d", v), rx_n, ok ? nb : 0);
            chk($sformatf("R7 frame_end count frame %0d", v), eof_n, ok);
            if (ok != 0 && rx_n >= 1)
                chk($sformatf("R2 R3 R5 R6 byte0 frame %0d", v),
                    int'(rx_buf[0]), int'(VEC[v][15:8]));
            if (ok != 0 && nb > 1 && rx_n >= 2)
                chk($sformatf("R2 R3 R6 R9 byte1 frame %0d", v),
                    int'(rx_buf[1]), int'(VEC[v][7:0]));
        end

        // R8: frame cut off three bits into its second byte
        start_frame(10);
        send_byte(8'hC3);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        go_idle();
        chk("R8 partial byte dropped count", rx_n, 1);
        if (rx_n >= 1) chk("R8 whole byte kept", int'(rx_buf[0]), 8'hC3);
        chk("R7 frame_end after partial", eof_n, 1);

        // R8: next frame realigns from its own first data bit
        start_frame(8);
        send_byte(8'h96);
        go_idle();
        chk("R8 next frame count", rx_n, 1);
        if (rx_n >= 1) chk("R8 next frame byte", int'(rx_buf[0]), 8'h96);

        chk("R6 strobe one cycle wide", wide, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule